// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device-side logic of a small serial nonvolatile memory. A host talks to it over chip select, a shift clock and a serial data line, and receives serial data on a data-out pin with its own output enable. All pins are sampled on one fast system clock through synchronizers. The host raises chip select, clocks in a start bit, a 2-bit opcode and an address field, and the block then reads, writes, erases or changes its write-protect state. The word width comes from an organization pin: 16-bit words with `WADDR_W` address bits, or 8-bit bytes with one more address bit. The storage is a register array inside the block.

Every programming command runs a self-timed cycle of `PROG_CYCLES` system clocks. During that cycle all other commands are ignored. After reset, programming is locked until the host sends an unlock command. If the host lowers chip select for at least `CS_LOW_MIN` clocks and then raises it again while the cycle is running, the data-out pin reports whether the block is busy or ready.

Top module: `serial_eeprom_dev`

## Requirements
- R1: While chip select is high, zeros on the data line before the first sampled 1 are ignored. That first 1 is the start bit of a command.
- R2: Commands are decoded from the opcode that follows the start bit: 10 reads, 01 writes a word and 11 erases a word. Opcode 00 takes its meaning from the top two bits of the address field: 11 unlocks programming, 00 locks it, 10 erases the whole array and 01 writes one value to every word. The remaining address bits are don't-care but must still be clocked in.
- R3: With the organization pin at 1, words are 16 bits wide and the address is `WADDR_W` bits. With it at 0, words are 8 bits wide and the address is `WADDR_W`+1 bits. The 16-bit word w occupies byte 2w (upper half) and byte 2w+1 (lower half).
- R4: A read drives a 0 on data out at the rising shift-clock edge that takes in the last address bit. After that the word follows, most significant bit first, one bit per rising edge.
- R5: While chip select stays high after a read word, the next word follows on the next rising edge with no 0 in between. The address wraps from the last word to word 0.
- R6: After reset, programming is locked. A write, erase, erase-all or write-all sent while locked changes nothing and starts no busy cycle. Reads work whether programming is locked or not.
- R7: Once unlocked, programming stays unlocked across any number of commands, until a lock command or reset.
- R8: Erase sets the addressed word to all ones and erase-all sets the whole array to ones. A write stores its data with no prior erase. Write-all stores its data in every word.
- R9: A programming cycle lasts `PROG_CYCLES` clocks. It starts after the last data bit for writes, and after the last address bit for erases. Bits sent during the cycle have no effect until chip select has been low again.
- R10: If chip select is raised during a programming cycle after being low for at least `CS_LOW_MIN` clocks, the output enable goes high and data out shows 0 while busy and 1 once the cycle is done. If chip select is raised after a shorter low time, or only after the cycle has ended, the output enable stays low.
- R11: The output enable is low after reset and whenever the block is sending neither read data nor status. Lowering chip select ends a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on it |
| rst_n | input | 1 | Active-low reset; locks programming |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial shift clock from the host |
| di_i | input | 1 | Serial data in, taken at rising shift-clock edges |
| org_i | input | 1 | Organization: 1 for 16-bit words, 0 for 8-bit bytes |
| do_o | output | 1 | Serial data out: read bits or busy/ready status |
| do_oe_o | output | 1 | Output enable for do_o |

## Verification
Two functions can fall in the same cycle: the end of the self-timed programming cycle and the status view that chip select opens on data out. The bench raises chip select soon after a write, and checks the busy 0 early and the ready 1 after the cycle. In the same run it ignores the bits sent during the cycle, which a later read shows by an unchanged word. It also raises chip select after too short a low time, and after the cycle has ended, and requires the output enable to stay low in both cases. A second overlap is the last bit of a read word landing on the same edge as the address increment and wrap. It is judged by sequential reads that cross the top of the array in both organizations.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_HOLD, ST_PROG
  } eep_state_t;

  typedef enum logic [1:0] {
    OPC_SPECIAL = 2'b00,
    OPC_WRITE   = 2'b01,
    OPC_READ    = 2'b10,
    OPC_ERASE   = 2'b11
  } eep_opc_t;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLRALL = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/eep_pin_sync.sv
module eep_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic cs_o,
  output logic di_o,
  output logic sk_rise_o,
  output logic cs_rise_o
);
  logic [STAGES-1:0] cs_p, sk_p, di_p;
  logic sk_last, cs_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p    <= '0;
      sk_p    <= '0;
      di_p    <= '0;
      sk_last <= 1'b0;
      cs_last <= 1'b0;
    end else begin
      cs_p    <= {cs_p[STAGES-2:0], cs_i};
      sk_p    <= {sk_p[STAGES-2:0], sk_i};
      di_p    <= {di_p[STAGES-2:0], di_i};
      sk_last <= sk_p[STAGES-1];
      cs_last <= cs_p[STAGES-1];
    end
  end

  assign cs_o      = cs_p[STAGES-1];
  assign di_o      = di_p[STAGES-1];
  assign sk_rise_o = sk_p[STAGES-1] & ~sk_last;
  assign cs_rise_o = cs_p[STAGES-1] & ~cs_last;
endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer #(
  parameter int CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));

  // R9: a started cycle is busy on the next clock and ends right after done
  p_busy_after_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int WADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 we_i,
  input  logic                 all_i,
  input  logic                 org_i,
  input  logic [WADDR_W:0]     waddr_i,
  input  logic [15:0]          wdata_i,
  input  logic                 rorg_i,
  input  logic [WADDR_W:0]     raddr_i,
  output logic [15:0]          rdata_o
);
  localparam int BADDR_W = WADDR_W + 1;
  localparam int NBYTES  = 2 ** BADDR_W;

  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int i = 0; i < NBYTES; i++) begin
        logic hit;
        hit = org_i ? (BADDR_W'(i >> 1) == {1'b0, waddr_i[WADDR_W-1:0]})
                    : (BADDR_W'(i) == waddr_i);
        if (all_i || hit)
          mem[i] <= (org_i && (i % 2 == 0)) ? wdata_i[15:8] : wdata_i[7:0];
      end
    end
  end

  always_comb begin
    if (rorg_i)
      rdata_o = {mem[{raddr_i[WADDR_W-1:0], 1'b0}], mem[{raddr_i[WADDR_W-1:0], 1'b1}]};
    else
      rdata_o = {8'h00, mem[raddr_i]};
  end
endmodule

// File: rtl/serial_eeprom_dev.sv
module serial_eeprom_dev #(
  parameter int WADDR_W     = 4,
  parameter int PROG_CYCLES = 40,
  parameter int CS_LOW_MIN  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  input  logic org_i,
  output logic do_o,
  output logic do_oe_o
);
  import eep_pkg::*;

  localparam int BADDR_W = WADDR_W + 1;
  localparam int MAXBITS = (BADDR_W > 16) ? BADDR_W : 16;
  localparam int CNT_W   = $clog2(MAXBITS + 1);
  localparam int LOWC_W  = $clog2(CS_LOW_MIN + 1);

  logic cs_s, di_s, sk_rise, cs_rise;
  logic busy, done;

  eep_state_t          st_q;
  eep_opc_t            opc_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BADDR_W-1:0]  addr_q;
  logic [15:0]         data_q;
  logic                org_q;
  logic                en_q;
  logic [15:0]         rd_word_q;
  logic [3:0]          bit_idx_q;
  logic                rd_active_q, do_q;
  logic                stat_on_q;
  logic [LOWC_W-1:0]   low_cnt_q;

  logic [BADDR_W-1:0]  addr_mask, addr_next, addr_full, addr_inc, arr_raddr, prog_addr;
  logic [15:0]         data_next, prog_data, arr_rdata;
  logic [1:0]          sub_code;
  logic [3:0]          dw_last;
  logic [CNT_W-1:0]    aw_last;
  logic                addr_last, data_last, prog_start, prog_all, low_ok;

  eep_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sk_i(sk_i), .di_i(di_i),
    .cs_o(cs_s), .di_o(di_s), .sk_rise_o(sk_rise), .cs_rise_o(cs_rise)
  );

  eep_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(prog_start), .busy_o(busy), .done_o(done)
  );

  eep_store #(.WADDR_W(WADDR_W)) u_store (
    .clk(clk), .we_i(prog_start), .all_i(prog_all), .org_i(org_q),
    .waddr_i(prog_addr), .wdata_i(prog_data),
    .rorg_i(org_q), .raddr_i(arr_raddr), .rdata_o(arr_rdata)
  );

  // field geometry for the organization latched at the start bit
  assign addr_mask = org_q ? {1'b0, {WADDR_W{1'b1}}} : {BADDR_W{1'b1}};
  assign aw_last   = org_q ? CNT_W'(WADDR_W - 1) : CNT_W'(BADDR_W - 1);
  assign dw_last   = org_q ? 4'd15 : 4'd7;
  assign addr_next = {addr_q[BADDR_W-2:0], di_s};
  assign addr_full = addr_next & addr_mask;
  assign addr_inc  = (addr_q + 1'b1) & addr_mask;
  assign data_next = {data_q[14:0], di_s};
  assign sub_code  = org_q ? addr_next[WADDR_W-1 -: 2] : addr_next[BADDR_W-1 -: 2];
  assign addr_last = (cnt_q == aw_last);
  assign data_last = (cnt_q == CNT_W'(dw_last));
  assign arr_raddr = (st_q == ST_ADDR) ? addr_full : addr_inc;
  assign prog_addr = (st_q == ST_ADDR) ? addr_full : addr_q;

  // programming launch, only while unlocked
  always_comb begin
    prog_start = 1'b0;
    prog_all   = 1'b0;
    prog_data  = 16'hFFFF;
    if (cs_s && sk_rise && en_q) begin
      if (st_q == ST_ADDR && addr_last) begin
        if (opc_q == OPC_ERASE) prog_start = 1'b1;
        if (opc_q == OPC_SPECIAL && sub_code == SUB_CLRALL) begin
          prog_start = 1'b1;
          prog_all   = 1'b1;
        end
      end else if (st_q == ST_DATA && data_last) begin
        prog_start = 1'b1;
        prog_all   = (opc_q == OPC_SPECIAL);
        prog_data  = data_next;
      end
    end
  end

  // command sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      opc_q       <= OPC_SPECIAL;
      cnt_q       <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      org_q       <= 1'b1;
      en_q        <= 1'b0;
      rd_word_q   <= '0;
      bit_idx_q   <= '0;
      rd_active_q <= 1'b0;
      do_q        <= 1'b0;
    end else if (!cs_s && st_q != ST_PROG) begin
      st_q        <= ST_IDLE;
      rd_active_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (sk_rise && di_s && !stat_on_q) begin
          st_q   <= ST_OPC;
          cnt_q  <= '0;
          addr_q <= '0;
          data_q <= '0;
          org_q  <= org_i;
        end
        ST_OPC: if (sk_rise) begin
          opc_q <= eep_opc_t'({opc_q[0], di_s});
          if (cnt_q == CNT_W'(1)) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_ADDR: if (sk_rise) begin
          addr_q <= addr_next;
          if (!addr_last) cnt_q <= cnt_q + 1'b1;
          else begin
            cnt_q  <= '0;
            addr_q <= addr_full;
            case (opc_q)
              OPC_READ: begin
                st_q        <= ST_READ;
                rd_word_q   <= arr_rdata;
                bit_idx_q   <= dw_last;
                do_q        <= 1'b0;
                rd_active_q <= 1'b1;
              end
              OPC_WRITE: st_q <= ST_DATA;
              OPC_ERASE: st_q <= prog_start ? ST_PROG : ST_HOLD;
              default: begin
                case (sub_code)
                  SUB_UNLOCK: begin en_q <= 1'b1; st_q <= ST_HOLD; end
                  SUB_LOCK:   begin en_q <= 1'b0; st_q <= ST_HOLD; end
                  SUB_FILL:   st_q <= ST_DATA;
                  default:    st_q <= prog_start ? ST_PROG : ST_HOLD;
                endcase
              end
            endcase
          end
        end
        ST_DATA: if (sk_rise) begin
          data_q <= data_next;
          if (data_last) st_q <= prog_start ? ST_PROG : ST_HOLD;
          else           cnt_q <= cnt_q + 1'b1;
        end
        ST_READ: if (sk_rise) begin
          do_q <= rd_word_q[bit_idx_q];
          if (bit_idx_q == 4'd0) begin
            addr_q    <= addr_inc;
            rd_word_q <= arr_rdata;
            bit_idx_q <= dw_last;
          end else bit_idx_q <= bit_idx_q - 1'b1;
        end
        ST_PROG: if (done) st_q <= cs_s ? ST_HOLD : ST_IDLE;
        default: ;
      endcase
    end
  end

  // ready/busy view opened by a chip-select rise during programming
  assign low_ok = (low_cnt_q >= LOWC_W'(CS_LOW_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      stat_on_q <= 1'b0;
    end else begin
      if (cs_s)         low_cnt_q <= '0;
      else if (!low_ok) low_cnt_q <= low_cnt_q + 1'b1;
      if (!cs_s)                          stat_on_q <= 1'b0;
      else if (cs_rise && busy && low_ok) stat_on_q <= 1'b1;
    end
  end

  assign do_oe_o = rd_active_q | stat_on_q;
  assign do_o    = stat_on_q ? ~busy : (rd_active_q & do_q);

  // R4: a read opens with a 0 and its bits move only after a shift-clock rise
  p_dummy_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active_q) |-> !do_o);
  p_out_on_sk_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active_q && $past(rd_active_q) && !$past(sk_rise)) |-> $stable(do_o));
  // R6: nothing is programmed while locked
  p_prog_needs_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> en_q);
  // R9: no new cycle launches while one runs
  p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !busy);
  // R10: status opens only on a rise seen during a busy cycle
  p_status_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_on_q) |-> $past(busy));
  // R11: read data and status never share the pin; chip select low ends a read
  p_oe_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_active_q && stat_on_q));
  p_cs_low_ends_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && st_q != ST_PROG) |=> !rd_active_q);
endmodule

// File: tb/serial_eeprom_dev_bench.sv
module serial_eeprom_dev_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int WADDR_W     = 4;
  localparam int PROG_CYCLES = 40;
  localparam int CS_LOW_MIN  = 4;
  localparam int SK_HALF     = 6;
  localparam int NW16        = 2 ** WADDR_W;
  localparam int NB          = 2 * NW16;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_o, do_oe;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  logic [7:0] mb [NB];

  serial_eeprom_dev #(.WADDR_W(WADDR_W), .PROG_CYCLES(PROG_CYCLES),
                      .CS_LOW_MIN(CS_LOW_MIN), .SYNC_STAGES(2)) u_serial_eeprom_dev (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di), .org_i(org),
    .do_o(do_o), .do_oe_o(do_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic b, output logic o);
    di = b;
    wait_clk(SK_HALF);
    sk = 1'b1;
    wait_clk(SK_HALF);
    o  = do_o;
    sk = 1'b0;
  endtask

  task automatic begin_cmd();
    cs = 1'b0;
    wait_clk(CS_LOW_MIN + 2);
    cs = 1'b1;
    wait_clk(2);
  endtask

  function automatic int aw_of(input logic orgv);
    return orgv ? WADDR_W : WADDR_W + 1;
  endfunction

  task automatic send_head(input logic [1:0] op, input logic orgv, input int a, output logic last);
    logic o;
    org = orgv;
    xfer(1'b1, o);
    xfer(op[1], o);
    xfer(op[0], o);
    for (int k = aw_of(orgv) - 1; k >= 0; k--) xfer(1'(a >> k), last);
  endtask

  task automatic send_data(input logic orgv, input logic [15:0] d);
    logic o;
    for (int k = (orgv ? 15 : 7); k >= 0; k--) xfer(d[k], o);
  endtask

  task automatic get_word(input logic orgv, output logic [15:0] w);
    logic o;
    w = '0;
    for (int k = 0; k < (orgv ? 16 : 8); k++) begin
      xfer(1'b0, o);
      w = {w[14:0], o};
    end
  endtask

  task automatic wait_prog();
    cs = 1'b0;
    wait_clk(PROG_CYCLES + 20);
  endtask

  function automatic logic [15:0] exp_word(input logic orgv, input int a);
    if (orgv) return {mb[(2*a) % NB], mb[(2*a+1) % NB]};
    return {8'h00, mb[a % NB]};
  endfunction

  task automatic model_write(input logic orgv, input int a, input logic [15:0] d);
    if (orgv) begin mb[2*a] = d[15:8]; mb[2*a+1] = d[7:0]; end
    else mb[a] = d[7:0];
  endtask

  task automatic special(input logic [1:0] sub, input logic orgv);
    logic o;
    begin_cmd();
    send_head(2'b00, orgv, int'(sub) << (aw_of(orgv) - 2), o);
    cs = 1'b0;
  endtask

  task automatic write_cmd(input logic orgv, input int a, input logic [15:0] d);
    logic o;
    begin_cmd();
    send_head(2'b01, orgv, a, o);
    send_data(orgv, d);
    wait_prog();
  endtask

  task automatic read_chk(input logic orgv, input int a, input int n, input string req);
    logic o;
    logic [15:0] w;
    begin_cmd();
    send_head(2'b10, orgv, a, o);
    chk({req, " R4 leading zero"}, {15'd0, o}, 16'd0);
    chk({req, " R11 oe during read"}, {15'd0, do_oe}, 16'd1);
    for (int k = 0; k < n; k++) begin
      get_word(orgv, w);
      chk({req, " R4 R5 data"}, w, exp_word(orgv, (a + k) % (orgv ? NW16 : NB)));
    end
    cs = 1'b0;
  endtask

  initial begin
    logic o;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R11 oe after reset", {15'd0, do_oe}, 16'd0);

    // R6: a write while locked starts no busy cycle
    begin_cmd();
    send_head(2'b01, 1'b1, 0, o);
    send_data(1'b1, 16'h1234);
    cs = 1'b0; wait_clk(CS_LOW_MIN + 2); cs = 1'b1; wait_clk(4);
    chk("R6 no busy when locked", {15'd0, do_oe}, 16'd0);
    cs = 1'b0;

    // R2 R8: unlock, erase the whole array
    special(2'b11, 1'b1);
    special(2'b10, 1'b1);
    wait_prog();
    for (int i = 0; i < NB; i++) mb[i] = 8'hFF;
    read_chk(1'b1, 0, NW16, "R8 erase-all");

    // R6: locked write ignored, read still works
    special(2'b00, 1'b1);
    write_cmd(1'b1, 2, 16'h0000);
    read_chk(1'b1, 2, 1, "R6 locked write ignored");
    special(2'b11, 1'b1);

    // R8 R7 R9 R10: sweep writes across every word; status on the first one
    for (int w = 0; w < NW16; w++) begin
      logic [15:0] d;
      d = 16'(w * 16'h1357) ^ 16'hC0DE;
      begin_cmd();
      send_head(2'b01, 1'b1, w, o);
      send_data(1'b1, d);
      if (w == 0) begin
        cs = 1'b0; wait_clk(CS_LOW_MIN + 2); cs = 1'b1; wait_clk(4);
        chk("R10 status oe", {15'd0, do_oe}, 16'd1);
        chk("R9 R10 busy shows 0", {15'd0, do_o}, 16'd0);
        wait_clk(PROG_CYCLES);
        chk("R9 R10 ready shows 1", {15'd0, do_o}, 16'd1);
      end
      wait_prog();
      model_write(1'b1, w, d);
    end
    for (int w = 0; w < NW16; w++) read_chk(1'b1, w, 1, "R3 x16 read");
    for (int b = 0; b < NB; b++) read_chk(1'b0, b, 1, "R3 x8 read");

    // R5: sequential reads across the wrap
    read_chk(1'b1, NW16 - 2, 4, "R5 x16 wrap");
    read_chk(1'b0, NB - 2, 4, "R5 x8 wrap");

    // R8: single-word erase, then a byte write without erase
    begin_cmd(); send_head(2'b11, 1'b1, 3, o); wait_prog();
    model_write(1'b1, 3, 16'hFFFF);
    read_chk(1'b1, 2, 3, "R8 erase word");
    write_cmd(1'b0, 9, 16'h003C);
    model_write(1'b0, 9, 16'h003C);
    read_chk(1'b1, 4, 1, "R8 R3 byte write");

    // R1: leading zeros before the start bit
    begin_cmd();
    for (int k = 0; k < 3; k++) xfer(1'b0, o);
    send_head(2'b10, 1'b1, 4, o);
    chk("R1 leading zero before word", {15'd0, o}, 16'd0);
    begin
      logic [15:0] w;
      get_word(1'b1, w);
      chk("R1 framed read", w, exp_word(1'b1, 4));
    end
    cs = 1'b0;

    // R11: dropping chip select mid-read releases the pin
    begin_cmd();
    send_head(2'b10, 1'b1, 5, o);
    for (int k = 0; k < 5; k++) xfer(1'b0, o);
    cs = 1'b0; wait_clk(6);
    chk("R11 oe after cs drop", {15'd0, do_oe}, 16'd0);

    // R9 R10: short low gives no status; a command sent during the cycle is ignored
    begin_cmd();
    send_head(2'b01, 1'b1, 1, o);
    send_data(1'b1, 16'hAAAA);
    model_write(1'b1, 1, 16'hAAAA);
    cs = 1'b0; wait_clk(2); cs = 1'b1; wait_clk(4);
    chk("R10 short low no status", {15'd0, do_oe}, 16'd0);
    send_head(2'b01, 1'b1, 6, o);
    send_data(1'b1, 16'h0000);
    wait_prog();
    read_chk(1'b1, 1, 1, "R9 first write kept");
    read_chk(1'b1, 6, 1, "R9 command during busy ignored");

    // R10: chip select raised only after the cycle ended
    write_cmd(1'b1, 7, 16'h5AA5);
    model_write(1'b1, 7, 16'h5AA5);
    cs = 1'b1; wait_clk(4);
    chk("R10 late raise no status", {15'd0, do_oe}, 16'd0);
    cs = 1'b0;

    // R7 R6: after lock, erase and erase-all do nothing
    special(2'b00, 1'b1);
    begin_cmd(); send_head(2'b11, 1'b1, 7, o); wait_prog();
    special(2'b10, 1'b0);
    wait_prog();
    read_chk(1'b1, 6, 2, "R7 lock holds");

    // R2 R8: write-all in both organizations
    special(2'b11, 1'b0);
    begin_cmd(); send_head(2'b00, 1'b0, 1 << 3, o); send_data(1'b0, 16'h005A); wait_prog();
    for (int i = 0; i < NB; i++) mb[i] = 8'h5A;
    read_chk(1'b1, 0, NW16, "R8 x8 write-all");
    begin_cmd(); send_head(2'b00, 1'b1, 1 << 2, o); send_data(1'b1, 16'h1234); wait_prog();
    for (int i = 0; i < NB; i++) mb[i] = (i % 2 == 0) ? 8'h12 : 8'h34;
    read_chk(1'b0, 0, 4, "R8 R3 x16 write-all");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule